// File: doc/BRIEF.md
# ACPI sleep-state power sequencer

This block follows the platform sleep state (S0 full power, S3 suspend-to-RAM, S5 soft-off) from two active-low sleep-control inputs and drives the digital enables of eight regulated rails and a USB supply switch. A millisecond tick drives a resume-reset timer that keeps the active-low resume reset asserted for a fixed time after the standby supply is reported good. Until that reset releases, the state is held at S5 and every rail is off.

The state machine accepts a sleep request only after it has stayed unchanged for a set number of clock cycles. It refuses a direct S3-to-S5 move, and it treats an S3 request seen while in S5 as a pass-through that is never taken as a destination. Protection results from the analog side arrive as digital flags: a fault input, one under-voltage flag per rail and one over-current flag per PWM rail. Each of these shuts its rails down through a sticky latch. The latch is released either when S5 is entered or only by a standby power cycle, as a configuration bit selects. All configuration arrives as static inputs. There is no streaming data path, so every pin is a plain level.

Top module: `pwrseq_top`

## Requirements
- R1: While in S3, a stable S5 request (slp_s5_n=0) is refused and the state stays S3. A stable S0 request (both sleep inputs high) moves it to S0.
- R2: From S0 a stable S3 request (slp_s5_n=1, slp_s3_n=0) enters S3 and a stable S5 request enters S5. From S5 a stable S0 request enters S0, while a stable S3 request leaves the state at S5. The state_o encoding is 2'b00 S5, 2'b01 S3, 2'b10 S0.
- R3: resume_rst_n is low out of reset and whenever stby_good is low. It goes high only after RSM_MS (default 66) tick_ms pulses have been counted while stby_good is high. While it is low, the state is S5 and all rails are off.
- R4: With fault_en=1, a low fault_n while in S0 shuts down rails 0 to 3 (memory PWM, termination PWM, PCIe linear, VID linear) one cycle later. Rails 4 to 7 are unaffected.
- R5: A high uv_flag[i] on an enabled rail shuts rail i down only when uv_en[i]=1. With uv_en[i]=0 the flag has no effect.
- R6: A high oc_flag[k] (k=0 memory PWM, k=1 termination PWM) shuts rail k down only when oc_en[k]=1.
- R7: A protection shutdown is sticky after its cause goes away. With recover_by_s5=1 it is cleared on entry to S5. With recover_by_s5=0 only a low stby_good clears it.
- R8: Rail map by state. Rails 2 and 3 are on only in S0. Rail 0 is on in S0, and in S3 when mem_mode=1. Rail 1 is on in S0, and in S3 when term_mode=1. Rail 4 is on in S0 and S3. Rails 5 to 7 are on in every state once resume reset has released. usb_en is on in S0 for every mode. In sleep it is on in S3 and S5 for usb_mode 00, on only in S3 for 01, and off for 10 or 11.
- R9: A change of the sleep request that lasts fewer than STABLE_CYC clock cycles has no effect on the state.
- R10: pgood_o is high only in S0, with main_pgood high and no protection latch set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_ms | input | 1 | One-cycle pulse every millisecond |
| stby_good | input | 1 | Standby supply good |
| slp_s3_n | input | 1 | Active-low suspend-to-RAM request |
| slp_s5_n | input | 1 | Active-low soft-off request |
| main_pgood | input | 1 | Main supply power good |
| fault_n | input | 1 | Active-low external fault |
| fault_en | input | 1 | Enables fault shutdown |
| recover_by_s5 | input | 1 | 1: S5 entry clears latches, 0: only a power cycle does |
| uv_flag | input | 8 | Per-rail under-voltage flags |
| uv_en | input | 8 | Per-rail under-voltage enables |
| oc_flag | input | 2 | PWM-rail over-current flags |
| oc_en | input | 2 | PWM-rail over-current enables |
| usb_mode | input | 2 | USB supply mode in sleep |
| mem_mode | input | 1 | Memory rail kept in S3 when 1 |
| term_mode | input | 1 | Termination rail kept in S3 when 1 |
| resume_rst_n | output | 1 | Active-low resume reset |
| state_o | output | 2 | Current sleep state |
| rail_en | output | 8 | Per-rail enables |
| usb_en | output | 1 | USB supply switch enable |
| pgood_o | output | 1 | Platform power good |

## Verification
A sleep-input change passes a two-stage synchronizer and then a STABLE_CYC stability window before the state register moves, about STABLE_CYC+3 cycles in all. The bench therefore waits 30 cycles after every sleep-input change before it samples state_o and the rails. Protection flags are captured in the latch on the next edge, and the rail enables and pgood_o follow that latch without another register. Mode and main_pgood changes reach usb_en, rail_en and pgood_o in the same cycle. The bench samples these a few cycles after the stimulus, always on the falling edge. resume_rst_n is registered behind the tick counter, so it rises on the second edge after the final tick. The bench checks it low after RSM_MS-1 ticks plus two cycles and high after the last tick plus two cycles.

// File: rtl/pwrseq_pkg.sv
package pwrseq_pkg;
  typedef enum logic [1:0] {
    ST_S5 = 2'b00,
    ST_S3 = 2'b01,
    ST_S0 = 2'b10
  } slp_state_t;

  localparam int NUM_RAILS  = 8;
  localparam int NUM_PWM    = 2;
  localparam int NUM_FAULTD = 4;

  localparam int RAIL_MEM  = 0;
  localparam int RAIL_TERM = 1;
  localparam int RAIL_PCIE = 2;
  localparam int RAIL_VID  = 3;
  localparam int RAIL_DUAL = 4;
endpackage

// File: rtl/pwrseq_rsm_timer.sv
module pwrseq_rsm_timer #(
  parameter int RSM_MS = 66
) (
  input  logic clk,
  input  logic rst_n,
  input  logic stby_good,
  input  logic tick_ms,
  output logic resume_rst_n
);
  localparam int CW = $clog2(RSM_MS + 1);
  localparam logic [CW-1:0] CNT_MAX = CW'(RSM_MS);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt          <= '0;
      resume_rst_n <= 1'b0;
    end else if (!stby_good) begin
      cnt          <= '0;
      resume_rst_n <= 1'b0;
    end else begin
      if (tick_ms && cnt != CNT_MAX) cnt <= cnt + 1'b1;
      resume_rst_n <= (cnt == CNT_MAX);
    end
  end

  // R3: loss of standby forces the resume reset on the next edge
  assert_resume_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !stby_good |=> !resume_rst_n);
endmodule

// File: rtl/pwrseq_req_filter.sv
module pwrseq_req_filter
  import pwrseq_pkg::*;
#(
  parameter int STABLE_CYC = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  slp_state_t raw_req,
  output slp_state_t req,
  output logic       req_ok
);
  localparam int CW = $clog2(STABLE_CYC + 1);
  localparam logic [CW-1:0] CNT_LAST = CW'(STABLE_CYC - 1);

  slp_state_t sync_q1, sync_q2, cand;
  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q1 <= ST_S5;
      sync_q2 <= ST_S5;
      cand    <= ST_S5;
      cnt     <= '0;
    end else begin
      sync_q1 <= raw_req;
      sync_q2 <= sync_q1;
      if (sync_q2 != cand) begin
        cand <= sync_q2;
        cnt  <= '0;
      end else if (cnt != CNT_LAST) begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  assign req    = cand;
  assign req_ok = (sync_q2 == cand) && (cnt == CNT_LAST);

  // R9: an accepted request has held its value over the previous cycle
  assert_stable_req_R9: assert property (@(posedge clk) disable iff (!rst_n)
    req_ok |-> $stable(cand));
endmodule

// File: rtl/pwrseq_state_fsm.sv
module pwrseq_state_fsm
  import pwrseq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       awake,
  input  slp_state_t req,
  input  logic       req_ok,
  output slp_state_t state,
  output logic       enter_s5
);
  slp_state_t nxt;

  always_comb begin
    nxt = state;
    if (!awake) begin
      nxt = ST_S5;
    end else if (req_ok) begin
      unique case (state)
        ST_S0:   nxt = req;
        ST_S3:   if (req == ST_S0) nxt = ST_S0;
        ST_S5:   if (req == ST_S0) nxt = ST_S0;
        default: nxt = ST_S5;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_S5;
      enter_s5 <= 1'b0;
    end else begin
      state    <= nxt;
      enter_s5 <= (nxt == ST_S5) && (state != ST_S5);
    end
  end

  // R1: suspend never drops straight to soft-off while standby is up
  assert_no_s3_to_s5_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_S3 && awake) |=> state != ST_S5);
  // R2: soft-off never settles in suspend
  assert_no_s5_to_s3_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_S5) |=> state != ST_S3);
endmodule

// File: rtl/pwrseq_protect.sv
module pwrseq_protect
  import pwrseq_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 awake,
  input  logic                 enter_s5,
  input  logic                 recover_by_s5,
  input  logic                 in_s0,
  input  logic                 fault_n,
  input  logic                 fault_en,
  input  logic [NUM_RAILS-1:0] rail_req,
  input  logic [NUM_RAILS-1:0] uv_flag,
  input  logic [NUM_RAILS-1:0] uv_en,
  input  logic [NUM_PWM-1:0]   oc_flag,
  input  logic [NUM_PWM-1:0]   oc_en,
  output logic [NUM_RAILS-1:0] prot
);
  logic                 fault_hit;
  logic                 clr;
  logic [NUM_RAILS-1:0] set_vec;

  assign fault_hit = fault_en && !fault_n && in_s0;
  assign clr       = !awake || (recover_by_s5 && enter_s5);

  for (genvar i = 0; i < NUM_RAILS; i++) begin : g_rail
    logic uv_hit;
    logic oc_hit;
    logic fl_hit;
    assign uv_hit = rail_req[i] && uv_flag[i] && uv_en[i];
    if (i < NUM_PWM) begin : g_oc
      assign oc_hit = rail_req[i] && oc_flag[i] && oc_en[i];
    end else begin : g_no_oc
      assign oc_hit = 1'b0;
    end
    if (i < NUM_FAULTD) begin : g_fl
      assign fl_hit = fault_hit;
    end else begin : g_no_fl
      assign fl_hit = 1'b0;
    end
    assign set_vec[i] = uv_hit || oc_hit || fl_hit;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      prot[i] <= 1'b0;
      else if (clr)    prot[i] <= 1'b0;
      else if (set_vec[i]) prot[i] <= 1'b1;
    end

    // R7: a latched shutdown persists until a release event
    assert_latch_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (prot[i] && !clr) |=> prot[i]);
  end

  // R4: an enabled fault in S0 latches all four main-state rails
  assert_fault_shutdown_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (fault_hit && !clr) |=> (&prot[NUM_FAULTD-1:0]));
endmodule

// File: rtl/pwrseq_top.sv
module pwrseq_top
  import pwrseq_pkg::*;
#(
  parameter int RSM_MS     = 66,
  parameter int STABLE_CYC = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick_ms,
  input  logic       stby_good,
  input  logic       slp_s3_n,
  input  logic       slp_s5_n,
  input  logic       main_pgood,
  input  logic       fault_n,
  input  logic       fault_en,
  input  logic       recover_by_s5,
  input  logic [7:0] uv_flag,
  input  logic [7:0] uv_en,
  input  logic [1:0] oc_flag,
  input  logic [1:0] oc_en,
  input  logic [1:0] usb_mode,
  input  logic       mem_mode,
  input  logic       term_mode,
  output logic       resume_rst_n,
  output logic [1:0] state_o,
  output logic [7:0] rail_en,
  output logic       usb_en,
  output logic       pgood_o
);
  slp_state_t           raw_req, req, state;
  logic                 req_ok, enter_s5;
  logic                 in_s0, in_s3, in_s5;
  logic [NUM_RAILS-1:0] rail_req, prot;

  always_comb begin
    if (!slp_s5_n)      raw_req = ST_S5;
    else if (!slp_s3_n) raw_req = ST_S3;
    else                raw_req = ST_S0;
  end

  pwrseq_rsm_timer #(.RSM_MS(RSM_MS)) u_timer (
    .clk(clk), .rst_n(rst_n), .stby_good(stby_good), .tick_ms(tick_ms),
    .resume_rst_n(resume_rst_n)
  );

  pwrseq_req_filter #(.STABLE_CYC(STABLE_CYC)) u_filter (
    .clk(clk), .rst_n(rst_n), .raw_req(raw_req), .req(req), .req_ok(req_ok)
  );

  pwrseq_state_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .awake(resume_rst_n), .req(req), .req_ok(req_ok),
    .state(state), .enter_s5(enter_s5)
  );

  assign in_s0 = (state == ST_S0);
  assign in_s3 = (state == ST_S3);
  assign in_s5 = (state == ST_S5);

  always_comb begin
    rail_req            = '0;
    rail_req[RAIL_MEM]  = in_s0 || (in_s3 && mem_mode);
    rail_req[RAIL_TERM] = in_s0 || (in_s3 && term_mode);
    rail_req[RAIL_PCIE] = in_s0;
    rail_req[RAIL_VID]  = in_s0;
    rail_req[RAIL_DUAL] = in_s0 || in_s3;
    for (int i = RAIL_DUAL + 1; i < NUM_RAILS; i++) rail_req[i] = 1'b1;
    if (!resume_rst_n) rail_req = '0;
  end

  pwrseq_protect u_prot (
    .clk(clk), .rst_n(rst_n), .awake(resume_rst_n), .enter_s5(enter_s5),
    .recover_by_s5(recover_by_s5), .in_s0(in_s0), .fault_n(fault_n),
    .fault_en(fault_en), .rail_req(rail_req), .uv_flag(uv_flag), .uv_en(uv_en),
    .oc_flag(oc_flag), .oc_en(oc_en), .prot(prot)
  );

  assign rail_en = rail_req & ~prot;
  assign usb_en  = resume_rst_n && (in_s0 ||
                   (usb_mode == 2'b00 && (in_s3 || in_s5)) ||
                   (usb_mode == 2'b01 && in_s3));
  assign pgood_o = in_s0 && main_pgood && !(|prot);
  assign state_o = state;
endmodule

// File: tb/tb_pwrseq_top.sv
module tb_pwrseq_top;
  localparam int RSM = 66;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick_ms = 1'b0, stby_good = 1'b0;
  logic slp_s3_n = 1'b0, slp_s5_n = 1'b0, main_pgood = 1'b1;
  logic fault_n = 1'b1, fault_en = 1'b0, recover_by_s5 = 1'b1;
  logic [7:0] uv_flag = 8'h00, uv_en = 8'hFF;
  logic [1:0] oc_flag = 2'b00, oc_en = 2'b11, usb_mode = 2'b00;
  logic mem_mode = 1'b1, term_mode = 1'b0;
  logic resume_rst_n, usb_en, pgood_o;
  logic [1:0] state_o;
  logic [7:0] rail_en;
  int nchk = 0, nbad = 0;

  always #5 clk = ~clk;

  pwrseq_top dut (
    .clk(clk), .rst_n(rst_n), .tick_ms(tick_ms), .stby_good(stby_good),
    .slp_s3_n(slp_s3_n), .slp_s5_n(slp_s5_n), .main_pgood(main_pgood),
    .fault_n(fault_n), .fault_en(fault_en), .recover_by_s5(recover_by_s5),
    .uv_flag(uv_flag), .uv_en(uv_en), .oc_flag(oc_flag), .oc_en(oc_en),
    .usb_mode(usb_mode), .mem_mode(mem_mode), .term_mode(term_mode),
    .resume_rst_n(resume_rst_n), .state_o(state_o), .rail_en(rail_en),
    .usb_en(usb_en), .pgood_o(pgood_o)
  );

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    nchk++;
    if (act !== exp) begin
      nbad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic ticks(input int n);
    repeat (n) begin
      @(negedge clk) tick_ms = 1'b1;
      @(negedge clk) tick_ms = 1'b0;
    end
  endtask

  task automatic req(input logic s3n, input logic s5n);
    @(negedge clk);
    slp_s3_n = s3n;
    slp_s5_n = s5n;
    cyc(30);
  endtask

  task automatic t_reset;
    rst_n = 1'b0;
    cyc(4);
    chk("R3 reset resume_rst_n", 16'(resume_rst_n), 16'h0);
    chk("R3 reset state", 16'(state_o), 16'h0);
    chk("R3 reset rails", 16'(rail_en), 16'h00);
    chk("R10 reset pgood", 16'(pgood_o), 16'h0);
    rst_n = 1'b1;
    cyc(2);
  endtask

  task automatic t_resume;
    stby_good = 1'b1;
    ticks(RSM - 1);
    cyc(2);
    chk("R3 resume still low", 16'(resume_rst_n), 16'h0);
    ticks(1);
    cyc(2);
    chk("R3 resume released", 16'(resume_rst_n), 16'h1);
    cyc(30);
    chk("R2 idle in S5", 16'(state_o), 16'h0);
    chk("R8 S5 rails", 16'(rail_en), 16'hE0);
    chk("R8 S5 usb dual", 16'(usb_en), 16'h1);
  endtask

  task automatic t_wake;
    req(1'b1, 1'b1);
    chk("R2 S5 to S0", 16'(state_o), 16'h2);
    chk("R8 S0 rails", 16'(rail_en), 16'hFF);
    chk("R10 pgood in S0", 16'(pgood_o), 16'h1);
    main_pgood = 1'b0;
    cyc(1);
    chk("R10 pgood main low", 16'(pgood_o), 16'h0);
    main_pgood = 1'b1;
    cyc(1);
  endtask

  task automatic t_debounce;
    @(negedge clk) slp_s3_n = 1'b0;
    cyc(10);
    slp_s3_n = 1'b1;
    cyc(30);
    chk("R9 glitch ignored", 16'(state_o), 16'h2);
    req(1'b0, 1'b1);
    chk("R2 S0 to S3", 16'(state_o), 16'h1);
  endtask

  task automatic t_s3_rails;
    chk("R8 S3 rails", 16'(rail_en), 16'hF1);
    chk("R10 no pgood in S3", 16'(pgood_o), 16'h0);
    chk("R8 S3 usb dual", 16'(usb_en), 16'h1);
    usb_mode = 2'b01;
    cyc(1);
    chk("R8 S3 usb str", 16'(usb_en), 16'h1);
    usb_mode = 2'b10;
    cyc(1);
    chk("R8 S3 usb off", 16'(usb_en), 16'h0);
    usb_mode = 2'b00;
  endtask

  task automatic t_transitions;
    req(1'b0, 1'b0);
    chk("R1 S3 to S5 refused", 16'(state_o), 16'h1);
    req(1'b1, 1'b1);
    chk("R1 S3 to S0", 16'(state_o), 16'h2);
    req(1'b1, 1'b0);
    chk("R2 S0 to S5", 16'(state_o), 16'h0);
    req(1'b0, 1'b1);
    chk("R2 S5 stays on S3 request", 16'(state_o), 16'h0);
    req(1'b1, 1'b1);
    chk("R2 S5 back to S0", 16'(state_o), 16'h2);
  endtask

  task automatic t_fault;
    fault_en = 1'b1;
    @(negedge clk) fault_n = 1'b0;
    cyc(3);
    chk("R4 fault rails", 16'(rail_en), 16'hF0);
    chk("R10 pgood after fault", 16'(pgood_o), 16'h0);
    fault_n = 1'b1;
    cyc(3);
    chk("R7 fault latched", 16'(rail_en), 16'hF0);
    req(1'b1, 1'b0);
    req(1'b1, 1'b1);
    chk("R7 S5 toggle state", 16'(state_o), 16'h2);
    chk("R7 S5 toggle released", 16'(rail_en), 16'hFF);
    fault_en = 1'b0;
  endtask

  task automatic t_uv;
    uv_en[5] = 1'b0;
    @(negedge clk) uv_flag = 8'h60;
    cyc(3);
    chk("R5 uv masked and enabled", 16'(rail_en), 16'hBF);
    uv_flag = 8'h00;
    recover_by_s5 = 1'b0;
    req(1'b1, 1'b0);
    req(1'b1, 1'b1);
    chk("R7 S5 toggle not enough", 16'(rail_en), 16'hBF);
    @(negedge clk) stby_good = 1'b0;
    cyc(2);
    chk("R3 resume on standby loss", 16'(resume_rst_n), 16'h0);
    stby_good = 1'b1;
    ticks(RSM);
    cyc(30);
    chk("R7 power cycle state", 16'(state_o), 16'h2);
    chk("R7 power cycle released", 16'(rail_en), 16'hFF);
    recover_by_s5 = 1'b1;
    uv_en = 8'hFF;
  endtask

  task automatic t_oc;
    oc_en = 2'b01;
    @(negedge clk) oc_flag = 2'b11;
    cyc(3);
    chk("R6 oc enabled and masked", 16'(rail_en), 16'hFE);
    oc_flag = 2'b00;
  endtask

  initial begin
    t_reset();
    t_resume();
    t_wake();
    t_debounce();
    t_s3_rails();
    t_transitions();
    t_fault();
    t_uv();
    t_oc();
    $display("test done: total=%0d bad=%0d", nchk, nbad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    nchk++;
    nbad++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("test done: total=%0d bad=%0d", nchk, nbad);
    $finish;
  end
endmodule